// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address stream for a single SDRAM read or write burst. The controller supplies a start column and a small mode word: a burst length code, an ordering bit and a write-single bit. It then pulses `start_i`. From the next cycle on, the block emits one column per clock and marks the final beat. An early terminate input cuts a burst short at any beat.

Addresses stay inside an aligned block whose size equals the burst length. The low column bits walk through the block in either sequential or interleaved order, and the upper bits hold still. A full-page length is available with sequential order only. It walks the whole row, wrapping from the top column to column 0, and it ends only on terminate. Command encoding, bank and row handling, refresh and data latency are outside this block.

Top module: `burst_col_seq`

## Requirements
- R1: The length code selects the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 with sequential order (`itype_i`=0) gives full page.
- R2: In sequential order (`itype_i`=0) with a length BL of 8 or less, beat k has low log2(BL) bits equal to (start + k) mod BL, and all higher column bits equal those of the start column.
- R3: In interleaved order (`itype_i`=1), beat k has low log2(BL) bits equal to start XOR k, and all higher bits equal those of the start column.
- R4: A full-page burst outputs start, start+1, ... modulo 512. Column 511 is followed by column 0, and the burst continues until terminate.
- R5: If `term_i` is high during a beat, that beat carries `last_o`=1 and is the final beat. If terminate coincides with the natural final beat, the burst still ends there with exactly that number of beats.
- R6: Length codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with `itype_i`=1, are reserved. For these the burst is a single beat at the start column, and `err_o` is high on that beat.
- R7: When `wbm_i`=1 and `write_i`=1 at start, the burst is a single beat whatever the length code. When `wbm_i`=1 and `write_i`=0, the programmed length applies.
- R8: Beat 0 appears in the cycle after the cycle in which `start_i` is sampled. Beats follow on consecutive cycles with `busy_o` high, and `busy_o` is low in the cycle after the final beat.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The current burst continues unchanged, and no extra beats follow it.
- R10: After reset `busy_o`, `last_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a burst (sampled when idle) |
| write_i | input | 1 | Access is a write |
| col_i | input | 9 | Start column |
| bl_code_i | input | 3 | Burst length code |
| itype_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| wbm_i | input | 1 | Writes are single-beat |
| term_i | input | 1 | Terminate the burst on the current beat |
| col_o | output | 9 | Column for the current beat |
| busy_o | output | 1 | A beat is on `col_o` |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Reserved mode was requested (burst is single-beat) |

## Verification
The natural end of a burst and a terminate request can land on the same beat. The bench provokes this by raising `term_i` on beat 3 of a 4-beat burst. It then requires exactly four beats, `last_o` only on the fourth, and `busy_o` low afterwards. A second overlap, a start request arriving mid-burst, is judged by the scoreboard: any beat beyond the queued expectation counts as a mismatch.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam logic [2:0] BL_FULL = 3'b111;

  typedef struct packed {
    logic [1:0] lg;    // log2 of burst length (0..3)
    logic       full;  // full-page burst
    logic       err;   // reserved mode requested
  } bsq_len_t;
endpackage

// File: rtl/bsq_mode_dec.sv
module bsq_mode_dec
  import bsq_pkg::*;
(
  input  logic [2:0] code_i,
  input  logic       itype_i,
  input  logic       wbm_i,
  input  logic       write_i,
  output bsq_len_t   len_o
);
  always_comb begin
    len_o = '0;
    if (code_i[2] == 1'b0) begin
      len_o.lg = code_i[1:0];
    end else if (code_i == BL_FULL && !itype_i) begin
      len_o.full = 1'b1;
    end else begin
      len_o.err = 1'b1;
    end
    if (wbm_i && write_i) begin
      len_o.lg   = 2'd0;
      len_o.full = 1'b0;
    end
  end
endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [1:0]       lg_i,
  input  logic             full_i,
  input  logic             itype_i,
  output logic [COL_W-1:0] col_o,
  output logic [COL_W-1:0] end_o
);
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] low;

  always_comb begin
    mask  = full_i ? '1 : ((COL_W'(1) << lg_i) - COL_W'(1));
    low   = itype_i ? (base_i ^ beat_i) : (base_i + beat_i);
    col_o = (base_i & ~mask) | (low & mask);
    end_o = mask;  // beat index of natural last beat
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bsq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             itype_i,
  input  logic             wbm_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             busy_o,
  output logic             last_o,
  output logic             err_o
);
  bsq_len_t         len_d, len_q;
  logic             busy_q, itype_q;
  logic [COL_W-1:0] base_q, beat_q, end_beat;

  bsq_mode_dec i_dec (
    .code_i  (bl_code_i),
    .itype_i (itype_i),
    .wbm_i   (wbm_i),
    .write_i (write_i),
    .len_o   (len_d)
  );

  bsq_addr_gen #(.COL_W(COL_W)) i_gen (
    .base_i  (base_q),
    .beat_i  (beat_q),
    .lg_i    (len_q.lg),
    .full_i  (len_q.full),
    .itype_i (itype_q),
    .col_o   (col_o),
    .end_o   (end_beat)
  );

  always_comb begin
    last_o = busy_q && (term_i || (!len_q.full && beat_q == end_beat));
    busy_o = busy_q;
    err_o  = busy_q && len_q.err;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      itype_q <= 1'b0;
      base_q  <= '0;
      beat_q  <= '0;
      len_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        itype_q <= itype_i;
        base_q  <= col_i;
        beat_q  <= '0;
        len_q   <= len_d;
      end
    end else if (last_o) begin
      busy_q <= 1'b0;
    end else begin
      beat_q <= beat_q + COL_W'(1);
    end
  end

  AST_LAST_DROPS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_o); // R8
  AST_ERR_SINGLE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> last_o); // R6
  AST_BLOCK_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && !len_q.full |-> $stable(col_o[COL_W-1:3])); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last_o && start_i |=> busy_o && $stable(base_q)); // R9
  AST_PAGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && len_q.full && !last_o |=> col_o == $past(col_o) + COL_W'(1)); // R4
endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, write_i = 1'b0, itype_i = 1'b0, wbm_i = 1'b0, term_i = 1'b0;
  logic [8:0] col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic [8:0] col_o;
  logic       busy_o, last_o, err_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R10";
  logic [8:0] exp_col_q[$];
  bit         exp_last_q[$];

  always #10 clk = ~clk;

  burst_col_seq i_burst_col_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .write_i(write_i),
    .col_i(col_i), .bl_code_i(bl_code_i), .itype_i(itype_i), .wbm_i(wbm_i),
    .term_i(term_i), .col_o(col_o), .busy_o(busy_o), .last_o(last_o), .err_o(err_o)
  );

  task automatic chk(string tag, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_col(int start, int k, int n, bit full, bit il);
    int off, o;
    if (full) return (start + k) % 512;
    off = start % n;
    o = il ? (off ^ k) : ((off + k) % n);
    return start - off + o;
  endfunction

  // monitor: sample a quarter cycle after the negedge
  always @(negedge clk) begin
    #5;
    if (rst_n && busy_o) begin
      if (exp_col_q.size() == 0) begin
        chk({cur_tag, " extra beat"}, 1'b0, int'(col_o), -1);
      end else begin
        logic [8:0] ec;
        bit el;
        ec = exp_col_q.pop_front();
        el = exp_last_q.pop_front();
        chk({cur_tag, " col"}, col_o == ec, int'(col_o), int'(ec));
        chk({cur_tag, " last"}, last_o == el, int'(last_o), int'(el));
      end
    end
  end

  task automatic burst(string tag, int start, logic [2:0] code, bit il, bit wbm, bit wr,
                       int term_at, int ign_at, bit exp_err);
    int n, beats;
    bit full;
    full = 0;
    n = 1;
    if (exp_err || (wbm && wr)) n = 1;
    else if (code == 3'b111) full = 1;
    else n = 1 << code[1:0];
    beats = full ? term_at + 1 : ((term_at >= 0 && term_at < n) ? term_at + 1 : n);
    cur_tag = tag;
    for (int k = 0; k < beats; k++) begin
      exp_col_q.push_back(9'(ref_col(start, k, n, full, il)));
      exp_last_q.push_back(k == beats - 1);
    end
    @(negedge clk);
    col_i = 9'(start); bl_code_i = code; itype_i = il; wbm_i = wbm; write_i = wr;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int j = 0; j < 700; j++) begin
      term_i = (j == term_at);
      if (j == ign_at) begin
        start_i = 1'b1;
        col_i = col_i ^ 9'h155;
      end else begin
        start_i = 1'b0;
      end
      if (j == 0) begin
        #5;
        chk({tag, " err"}, err_o == exp_err, int'(err_o), int'(exp_err));
      end
      @(negedge clk);
      if (!busy_o && exp_col_q.size() == 0) break;
    end
    term_i = 1'b0;
    start_i = 1'b0;
    #5;
    chk({tag, " idle after burst"}, !busy_o, int'(busy_o), 0);
    chk({tag, " queue drained"}, exp_col_q.size() == 0, exp_col_q.size(), 0);
    exp_col_q.delete();
    exp_last_q.delete();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk("R10 busy", !busy_o, int'(busy_o), 0);
    chk("R10 last", !last_o, int'(last_o), 0);
    chk("R10 err", !err_o, int'(err_o), 0);
    rst_n = 1'b1;
    // R1 R2 R3: every length, ordering and start offset
    for (int il = 0; il < 2; il++)
      for (int c = 0; c < 4; c++)
        for (int s = 0; s < 8; s++)
          burst(il ? "R3 interleaved" : "R2 sequential", (s + 8 * (c * 11 + s * 5 + il * 3)) % 512,
                3'(c), bit'(il), 0, 0, -1, -1, 0);
    burst("R1 len8 high cols", 9'h1fd, 3'b011, 0, 0, 0, -1, -1, 0);
    // R4 full page wrap at 511
    burst("R4 page wrap", 509, 3'b111, 0, 0, 0, 5, -1, 0);
    burst("R4 page long", 3, 3'b111, 0, 0, 1, 520, -1, 0);
    // R5 terminate mid burst and on natural last beat
    burst("R5 term mid", 42, 3'b011, 0, 0, 0, 2, -1, 0);
    burst("R5 term on last", 21, 3'b010, 1, 0, 0, 3, -1, 0);
    burst("R5 term beat0", 100, 3'b111, 0, 0, 0, 0, -1, 0);
    // R6 reserved codes
    burst("R6 code100", 77, 3'b100, 0, 0, 0, -1, -1, 1);
    burst("R6 code110", 78, 3'b110, 1, 0, 0, -1, -1, 1);
    burst("R6 page interleaved", 79, 3'b111, 1, 0, 0, -1, -1, 1);
    // R7 write single mode
    burst("R7 write single", 13, 3'b011, 0, 1, 1, -1, -1, 0);
    burst("R7 read keeps len", 13, 3'b011, 0, 1, 0, -1, -1, 0);
    burst("R7 write no wbm", 6, 3'b010, 1, 0, 1, -1, -1, 0);
    // R9 start while busy
    burst("R9 start ignored", 200, 3'b011, 0, 0, 0, -1, 2, 0);
    burst("R9 start on last", 300, 3'b001, 0, 0, 0, -1, 1, 0);
    // R8 back-to-back acceptance after idle
    burst("R8 follow-up", 5, 3'b001, 1, 0, 0, -1, -1, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule